// File: doc/BRIEF.md
# Multi-queue transmit channel scheduler

This block decides, once per clock, which of sixteen circular transmit descriptor rings gets to hand its next entry to one of eight transmit FIFO channels. Every ring has an 8-bit write index (advanced by software as descriptors are queued) and an 8-bit read index (advanced by the block on each grant), a per-ring empty flag, and a 10-bit control word. The control word holds an active bit, the number of the channel the ring feeds, a window-space flag and a block-ack/in-order mode bit. Several rings may feed the same channel. Within one channel the rings take turns in round-robin order. Across channels a fixed priority applies, and the higher channel number wins.

Software reaches the state through a single-cycle register port. The read data is combinational from the address. The control word carries its own per-bit write mask, so software can change one field without first reading the word. The empty flags can be forced through a masked register during re-initialisation, and they also follow the pointers on their own.

The grant leaves on a valid-only stream: `tx_valid`, `tx_queue`, `tx_chan` and `tx_index`. Back-pressure comes from the per-channel `ch_ready` inputs. A channel whose ready is low is left out of the selection, so `tx_valid` high always means a transfer that takes place in that cycle. Because `tx_valid` depends on `ch_ready`, a consumer must not derive its ready from `tx_valid`.

Top module: `txs_sched`

Register map (byte-free word addresses, `cfg_addr[7:4]` = group, `cfg_addr[3:0]` = ring or index):

| Address | Content |
|---|---|
| 0x00 | channel enable, bits 7:0 |
| 0x01 | empty flags, bits 15:0; on write, bits 31:16 mask bits 15:0 |
| 0x10+q | write index of ring q |
| 0x20+q | read index of ring q |
| 0x30+q | control word of ring q, bits 9:0; on write, bits 19:10 mask bits 9:0 |

## Requirements
- R1: After reset every index is 0, every empty flag is 1, every control word is 0, the channel enable register is 0 and `tx_valid` is low. Reads of unmapped addresses return 0.
- R2: A write to 0x30+q changes control bit i (i = 0..9) to `cfg_wdata[i]` only when `cfg_wdata[10+i]` is 1. Bit 0 is active, bits 4:1 are the channel number, bit 5 is window-space and bit 8 is block-ack mode. The word reads back at 0x30+q in bits 9:0.
- R3: Channel enable bit c (register 0x00) gates channel c. No grant goes to a channel whose enable bit is 0.
- R4: A ring is served only when it is active, its empty flag is 0, its channel field is below 8, and that channel is enabled and ready.
- R5: A grant shows `tx_valid`=1 with the ring, its channel and the current read index in the same cycle. The ring's read index then reads one higher, modulo 256, from the next cycle on (so 255 wraps to 0).
- R6: Whenever a ring's write index or read index is written, or the ring is granted, its empty flag becomes (new read index == new write index).
- R7: A write to 0x01 sets empty flag q to `cfg_wdata[q]` only where `cfg_wdata[16+q]` is 1. In that cycle the forced value takes precedence over the automatic update.
- R8: Among the ready rings of one channel, the search starts at the ring after the one last granted on that channel. After reset the search starts at ring 0.
- R9: At most one grant occurs per cycle. When several channels have a ready ring, the highest channel number wins.
- R10: A software write to a ring's read index in the same cycle as that ring's grant takes precedence over the increment.
- R11: A channel with `ch_ready` low is skipped and its rings keep their round-robin place. A lower channel may then be served in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cfg_wr | input | 1 | register write strobe |
| cfg_addr | input | 8 | register address for both read and write |
| cfg_wdata | input | 32 | register write data |
| cfg_rdata | output | 32 | register read data for `cfg_addr`, combinational |
| ch_ready | input | 8 | per-channel ready |
| tx_valid | output | 1 | a grant takes place this cycle |
| tx_queue | output | 4 | granted ring |
| tx_chan | output | 3 | channel that receives the entry |
| tx_index | output | 8 | read index of the granted entry |

## Verification
The bench goes after several corner cases:
- **Read index wrap from 255 to 0.** A bad adder would stall the ring or let it run past its write index.
- **Round-robin rotation among rings on one channel.** A design that always restarts at ring 0 would starve the later rings.
- **Priority when a higher channel drops its ready.** Here a lower channel must win, and the dropped channel's rings must keep their turn.
- **Forcing an empty flag while a ring holds data, and clearing a force with a zero mask.** A design that ignores the mask, or that gates on index equality instead of the flag, serves the wrong rings.
- **A read-index write that collides with a grant.** A design that applies the increment here leaves the index off by one.
- **Rings that are inactive or mapped to a nonexistent channel.** These must never appear on `tx_valid`.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int ADDR_W         = 8;
  localparam int DATA_W         = 32;
  localparam int IDX_W          = 4;   // ring / register index field of the address
  localparam int ST_W           = 10;  // stored control word width
  localparam int CH_FLD_W       = 4;   // channel number field inside the control word
  localparam int ST_ACT         = 0;
  localparam int ST_CH_LSB      = 1;
  localparam int ST_MASK_LSB    = 10;  // per-bit write enables of the control word
  localparam int EMPTY_MASK_LSB = 16;  // per-ring write enables of the empty register

  localparam logic [3:0] GRP_GLB = 4'h0;
  localparam logic [3:0] GRP_WR  = 4'h1;
  localparam logic [3:0] GRP_RD  = 4'h2;
  localparam logic [3:0] GRP_ST  = 4'h3;

  localparam logic [IDX_W-1:0] IDX_CHEN  = 4'h0;
  localparam logic [IDX_W-1:0] IDX_EMPTY = 4'h1;
endpackage

// File: rtl/txs_qregs.sv
module txs_qregs
  import txs_pkg::*;
#(
  parameter int NUM_Q  = 16,
  parameter int NUM_CH = 8,
  parameter int PTR_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_wr,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [DATA_W-1:0]          cfg_wdata,
  output logic [DATA_W-1:0]          cfg_rdata,
  input  logic                       gnt_valid,
  input  logic [$clog2(NUM_Q)-1:0]   gnt_q,
  output logic [NUM_CH-1:0]          chan_en,
  output logic [NUM_Q-1:0]           empty_vec,
  output logic [NUM_Q-1:0]           active_vec,
  output logic [NUM_Q*CH_FLD_W-1:0]  chan_flat,
  output logic [NUM_Q*PTR_W-1:0]     rd_flat
);
  localparam int QW = $clog2(NUM_Q);

  logic [3:0]             grp;
  logic [IDX_W-1:0]       idx;
  logic                   emp_wr;
  logic [NUM_Q*PTR_W-1:0] wr_flat;
  logic [NUM_Q*ST_W-1:0]  st_flat;

  assign grp    = cfg_addr[ADDR_W-1:IDX_W];
  assign idx    = cfg_addr[IDX_W-1:0];
  assign emp_wr = cfg_wr && (grp == GRP_GLB) && (idx == IDX_EMPTY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      chan_en <= '0;
    else if (cfg_wr && (grp == GRP_GLB) && (idx == IDX_CHEN))
      chan_en <= cfg_wdata[NUM_CH-1:0];
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : g_ring
    logic [PTR_W-1:0] rd_q, wr_q, rd_n, wr_n;
    logic [ST_W-1:0]  st_q, st_m;
    logic             e_q, sel, wr_hit, rd_hit, st_hit, gnt_hit;

    assign sel     = (idx == IDX_W'(q));
    assign wr_hit  = cfg_wr && (grp == GRP_WR) && sel;
    assign rd_hit  = cfg_wr && (grp == GRP_RD) && sel;
    assign st_hit  = cfg_wr && (grp == GRP_ST) && sel;
    assign gnt_hit = gnt_valid && (gnt_q == QW'(q));
    assign st_m    = cfg_wdata[ST_MASK_LSB +: ST_W];

    always_comb begin
      wr_n = wr_hit ? cfg_wdata[PTR_W-1:0] : wr_q;
      if (rd_hit)
        rd_n = cfg_wdata[PTR_W-1:0];
      else if (gnt_hit)
        rd_n = rd_q + 1'b1;
      else
        rd_n = rd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_q <= '0;
        wr_q <= '0;
        st_q <= '0;
        e_q  <= 1'b1;
      end else begin
        rd_q <= rd_n;
        wr_q <= wr_n;
        if (st_hit)
          st_q <= (st_q & ~st_m) | (cfg_wdata[ST_W-1:0] & st_m);
        if (emp_wr && cfg_wdata[EMPTY_MASK_LSB + q])
          e_q <= cfg_wdata[q];
        else if (wr_hit || rd_hit || gnt_hit)
          e_q <= (rd_n == wr_n);
      end
    end

    assign rd_flat[q*PTR_W +: PTR_W]         = rd_q;
    assign wr_flat[q*PTR_W +: PTR_W]         = wr_q;
    assign st_flat[q*ST_W +: ST_W]           = st_q;
    assign empty_vec[q]                      = e_q;
    assign active_vec[q]                     = st_q[ST_ACT];
    assign chan_flat[q*CH_FLD_W +: CH_FLD_W] = st_q[ST_CH_LSB +: CH_FLD_W];
  end

  always_comb begin
    cfg_rdata = '0;
    case (grp)
      GRP_GLB: begin
        if (idx == IDX_CHEN)       cfg_rdata = DATA_W'(chan_en);
        else if (idx == IDX_EMPTY) cfg_rdata = DATA_W'(empty_vec);
      end
      GRP_WR: if (int'(idx) < NUM_Q) cfg_rdata = DATA_W'(wr_flat[idx*PTR_W +: PTR_W]);
      GRP_RD: if (int'(idx) < NUM_Q) cfg_rdata = DATA_W'(rd_flat[idx*PTR_W +: PTR_W]);
      GRP_ST: if (int'(idx) < NUM_Q) cfg_rdata = DATA_W'(st_flat[idx*ST_W +: ST_W]);
      default: cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/txs_rr_arb.sv
module txs_rr_arb #(
  parameter int N = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  input  logic                 adv,
  output logic                 gnt_valid,
  output logic [$clog2(N)-1:0] gnt_idx
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] last;

  // Search starts one past the ring that was granted last on this channel.
  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = last;
    for (int k = 1; k <= N; k++) begin
      int t;
      t = int'(last) + k;
      if (t >= N) t = t - N;
      if (!gnt_valid && req[t]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IW'(t);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      last <= IW'(N - 1);
    else if (adv && gnt_valid)
      last <= gnt_idx;
  end
endmodule

// File: rtl/txs_ch_prio.sv
module txs_ch_prio #(
  parameter int NUM_CH = 8,
  parameter int IW     = 4
) (
  input  logic [NUM_CH-1:0]         ch_valid,
  input  logic [NUM_CH*IW-1:0]      ch_idx,
  output logic                      out_valid,
  output logic [$clog2(NUM_CH)-1:0] out_ch,
  output logic [IW-1:0]             out_idx
);
  localparam int CHW = $clog2(NUM_CH);

  // Ascending scan: the last hit, i.e. the highest channel, wins.
  always_comb begin
    out_valid = 1'b0;
    out_ch    = '0;
    out_idx   = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_valid[c]) begin
        out_valid = 1'b1;
        out_ch    = CHW'(c);
        out_idx   = ch_idx[c*IW +: IW];
      end
    end
  end
endmodule

// File: rtl/txs_sched.sv
module txs_sched
  import txs_pkg::*;
#(
  parameter int NUM_Q  = 16,
  parameter int NUM_CH = 8,
  parameter int PTR_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_wr,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [DATA_W-1:0]         cfg_wdata,
  output logic [DATA_W-1:0]         cfg_rdata,
  input  logic [NUM_CH-1:0]         ch_ready,
  output logic                      tx_valid,
  output logic [$clog2(NUM_Q)-1:0]  tx_queue,
  output logic [$clog2(NUM_CH)-1:0] tx_chan,
  output logic [PTR_W-1:0]          tx_index
);
  localparam int QW  = $clog2(NUM_Q);
  localparam int CHW = $clog2(NUM_CH);

  logic [NUM_CH-1:0]         chan_en;
  logic [NUM_Q-1:0]          empty_vec;
  logic [NUM_Q-1:0]          active_vec;
  logic [NUM_Q*CH_FLD_W-1:0] chan_flat;
  logic [NUM_Q*PTR_W-1:0]    rd_flat;
  logic [NUM_Q-1:0]          elig;
  logic [NUM_CH-1:0]         ch_valid;
  logic [NUM_CH*QW-1:0]      ch_idx;

  txs_qregs #(.NUM_Q(NUM_Q), .NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .gnt_valid  (tx_valid),
    .gnt_q      (tx_queue),
    .chan_en    (chan_en),
    .empty_vec  (empty_vec),
    .active_vec (active_vec),
    .chan_flat  (chan_flat),
    .rd_flat    (rd_flat)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_elig
    logic [CH_FLD_W-1:0] cf;
    logic [CHW-1:0]      ci;
    logic                in_rng;
    assign cf      = chan_flat[q*CH_FLD_W +: CH_FLD_W];
    assign ci      = cf[CHW-1:0];
    assign in_rng  = (cf < CH_FLD_W'(NUM_CH));
    assign elig[q] = active_vec[q] && !empty_vec[q] && in_rng && chan_en[ci] && ch_ready[ci];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [NUM_Q-1:0] req_c;
    logic             adv_c;
    always_comb begin
      for (int q = 0; q < NUM_Q; q++)
        req_c[q] = elig[q] && (chan_flat[q*CH_FLD_W +: CH_FLD_W] == CH_FLD_W'(c));
    end
    assign adv_c = tx_valid && (tx_chan == CHW'(c));
    txs_rr_arb #(.N(NUM_Q)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req_c),
      .adv       (adv_c),
      .gnt_valid (ch_valid[c]),
      .gnt_idx   (ch_idx[c*QW +: QW])
    );
  end

  txs_ch_prio #(.NUM_CH(NUM_CH), .IW(QW)) u_prio (
    .ch_valid  (ch_valid),
    .ch_idx    (ch_idx),
    .out_valid (tx_valid),
    .out_ch    (tx_chan),
    .out_idx   (tx_queue)
  );

  assign tx_index = rd_flat[tx_queue*PTR_W +: PTR_W];
endmodule

// File: rtl/txs_sched_chk.sv
module txs_sched_chk
  import txs_pkg::*;
#(
  parameter int NUM_Q  = 16,
  parameter int NUM_CH = 8,
  parameter int PTR_W  = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cfg_wr,
  input logic [ADDR_W-1:0]         cfg_addr,
  input logic [NUM_CH-1:0]         ch_ready,
  input logic                      tx_valid,
  input logic [$clog2(NUM_Q)-1:0]  tx_queue,
  input logic [$clog2(NUM_CH)-1:0] tx_chan,
  input logic [PTR_W-1:0]          tx_index,
  input logic [NUM_CH-1:0]         chan_en,
  input logic [NUM_Q-1:0]          empty_vec,
  input logic [NUM_Q-1:0]          active_vec,
  input logic [NUM_Q*CH_FLD_W-1:0] chan_flat,
  input logic [NUM_Q*PTR_W-1:0]    rd_flat
);
  localparam int QW = $clog2(NUM_Q);

  logic          sw_rd;
  logic          adv_d;
  logic [QW-1:0] q_d;
  logic [PTR_W-1:0] idx_d;

  assign sw_rd = cfg_wr && (cfg_addr == {GRP_RD, IDX_W'(tx_queue)});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adv_d <= 1'b0;
      q_d   <= '0;
      idx_d <= '0;
    end else begin
      adv_d <= tx_valid && !sw_rd;
      q_d   <= tx_queue;
      idx_d <= tx_index;
    end
  end

  AST_GNT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ch_ready[tx_chan]); // R11
  AST_GNT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> chan_en[tx_chan]); // R3
  AST_GNT_SERVABLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (active_vec[tx_queue] && !empty_vec[tx_queue])); // R4
  AST_GNT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (chan_flat[tx_queue*CH_FLD_W +: CH_FLD_W] == CH_FLD_W'(tx_chan))); // R2
  AST_RD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    adv_d |-> (rd_flat[q_d*PTR_W +: PTR_W] == PTR_W'(idx_d + 1'b1))); // R5
endmodule

bind txs_sched txs_sched_chk #(.NUM_Q(NUM_Q), .NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_addr   (cfg_addr),
  .ch_ready   (ch_ready),
  .tx_valid   (tx_valid),
  .tx_queue   (tx_queue),
  .tx_chan    (tx_chan),
  .tx_index   (tx_index),
  .chan_en    (chan_en),
  .empty_vec  (empty_vec),
  .active_vec (active_vec),
  .chan_flat  (chan_flat),
  .rd_flat    (rd_flat)
);

// File: tb/txs_sched_tb_top.sv
module txs_sched_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic [7:0]  ch_ready = 8'h00;
  logic        tx_valid;
  logic [3:0]  tx_queue;
  logic [2:0]  tx_chan;
  logic [7:0]  tx_index;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    started  = 0;
  bit    finished = 0;
  string cur_req  = "R1";

  // behavioural reference state
  int m_wr[16];
  int m_rd[16];
  int m_st[16];
  int m_rr[8];
  bit m_emp[16];
  int m_en;

  always #4 clk = ~clk;

  txs_sched dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ch_ready(ch_ready),
    .tx_valid(tx_valid), .tx_queue(tx_queue), .tx_chan(tx_chan), .tx_index(tx_index)
  );

  task automatic model_reset();
    for (int q = 0; q < 16; q++) begin
      m_wr[q] = 0; m_rd[q] = 0; m_st[q] = 0; m_emp[q] = 1;
    end
    for (int c = 0; c < 8; c++) m_rr[c] = 15;
    m_en = 0;
  endtask

  // R9 highest channel first, R8 rotation inside a channel, R4 eligibility
  task automatic pick(output bit f, output int gq, output int gc);
    f = 0; gq = 0; gc = 0;
    for (int c = 7; c >= 0; c--) begin
      if (!f && m_en[c] && ch_ready[c]) begin
        for (int k = 1; k <= 16; k++) begin
          int q;
          q = (m_rr[c] + k) % 16;
          if (!f && m_st[q][0] && !m_emp[q] && ((m_st[q] >> 1) & 15) == c) begin
            f = 1; gq = q; gc = c;
          end
        end
      end
    end
  endtask

  function automatic int exp_rdata(input int a);
    int g, i, r;
    g = a >> 4; i = a & 15; r = 0;
    case (g)
      0: if (i == 0) r = m_en;
         else if (i == 1) for (int q = 0; q < 16; q++) r |= int'(m_emp[q]) << q;
      1: r = m_wr[i];
      2: r = m_rd[i];
      3: r = m_st[i];
      default: r = 0;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (!rst_n) model_reset();
    else begin
      bit f; int gq, gc;
      int nrd[16]; int nwr[16]; bit touch[16];
      pick(f, gq, gc);
      for (int q = 0; q < 16; q++) begin nrd[q] = m_rd[q]; nwr[q] = m_wr[q]; touch[q] = 0; end
      if (f) begin nrd[gq] = (m_rd[gq] + 1) % 256; touch[gq] = 1; m_rr[gc] = gq; end
      if (cfg_wr) begin
        int g, i;
        g = cfg_addr >> 4; i = cfg_addr & 15;
        if (g == 1) begin nwr[i] = cfg_wdata & 255; touch[i] = 1; end
        if (g == 2) begin nrd[i] = cfg_wdata & 255; touch[i] = 1; end   // R10 write wins
        if (g == 3) for (int b = 0; b < 10; b++) if (cfg_wdata[10+b]) m_st[i][b] = cfg_wdata[b];
        if (g == 0 && i == 0) m_en = cfg_wdata & 255;
      end
      for (int q = 0; q < 16; q++) begin
        if (cfg_wr && cfg_addr == 8'h01 && cfg_wdata[16+q]) m_emp[q] = cfg_wdata[q];
        else if (touch[q]) m_emp[q] = (nrd[q] == nwr[q]);
        m_rd[q] = nrd[q]; m_wr[q] = nwr[q];
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (started && !finished) begin
      bit f; int gq, gc;
      pick(f, gq, gc);
      chk("tx_valid", int'(tx_valid), int'(f));
      if (f && tx_valid) begin
        chk("tx_queue", int'(tx_queue), gq);
        chk("tx_chan", int'(tx_chan), gc);
        chk("tx_index", int'(tx_index), m_rd[gq]);
      end
      chk("cfg_rdata", int'(cfg_rdata), exp_rdata(int'(cfg_addr)));
    end
  end

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
  endtask

  task automatic rreg(input logic [7:0] a);
    @(negedge clk);
    cfg_wr = 1'b0; cfg_addr = a;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); cfg_wr = 1'b0; end
  endtask

  function automatic logic [31:0] stf(input int act, input int ch);
    return (32'h3FF << 10) | 32'(ch << 1) | 32'(act);
  endfunction

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    cur_req = "R1";
    rreg(8'h00); rreg(8'h01); rreg(8'h10); rreg(8'h25); rreg(8'h3F); rreg(8'h77);
    // R2 masked control word
    cur_req = "R2";
    wreg(8'h30, 32'h0000_03FF); rreg(8'h30);
    wreg(8'h30, 32'h0004_8400 | 32'h3FF); rreg(8'h30);
    wreg(8'h30, 32'h0000_0400); rreg(8'h30);
    wreg(8'h30, 32'h000F_FC00); rreg(8'h30);
    // R3 channel disabled: nothing served
    cur_req = "R3";
    ch_ready = 8'hFF;
    wreg(8'h30, stf(1, 1)); wreg(8'h31, stf(1, 1)); wreg(8'h32, stf(1, 1));
    wreg(8'h10, 3); wreg(8'h11, 3); wreg(8'h12, 3);
    rreg(8'h01); idle(3);
    // R8 round robin within channel 1
    cur_req = "R8";
    wreg(8'h00, 32'hFF); rreg(8'h21); idle(10);
    // R6 empty tracking on pointer writes
    cur_req = "R6";
    rreg(8'h01); wreg(8'h11, 5); rreg(8'h01); idle(3);
    // R9 channel priority
    cur_req = "R9";
    wreg(8'h33, stf(1, 5)); wreg(8'h34, stf(1, 2));
    wreg(8'h14, 2); wreg(8'h13, 2); idle(6);
    // R11 ready low on channel 5
    cur_req = "R11";
    ch_ready = 8'hDF;
    wreg(8'h13, 4); wreg(8'h14, 4); idle(4);
    ch_ready = 8'hFF; idle(4);
    // R7 forced empty flags
    cur_req = "R7";
    ch_ready = 8'h00;
    wreg(8'h35, stf(1, 3)); wreg(8'h15, 6);
    wreg(8'h01, (32'h1 << 21) | (32'h1 << 5));
    ch_ready = 8'hFF; rreg(8'h01); idle(2);
    wreg(8'h01, 32'h0000_FFFF); rreg(8'h01); idle(2);
    wreg(8'h01, 32'h1 << 21); idle(8);
    // R10 software read-index write collides with grant
    cur_req = "R10";
    wreg(8'h36, stf(1, 4)); wreg(8'h16, 10);
    wreg(8'h26, 8); rreg(8'h26); idle(4);
    // R4 inactive ring and channel number out of range
    cur_req = "R4";
    wreg(8'h37, stf(1, 9)); wreg(8'h17, 4);
    wreg(8'h18, 4); rreg(8'h27); idle(4);
    // R5 read index wrap
    cur_req = "R5";
    ch_ready = 8'h00;
    wreg(8'h39, stf(1, 0)); wreg(8'h29, 254); wreg(8'h19, 1);
    ch_ready = 8'hFF; rreg(8'h29); idle(5); rreg(8'h29);
    // R3 disabling a channel mid-stream
    cur_req = "R3";
    wreg(8'h00, 32'hFE); wreg(8'h19, 5); idle(3);
    wreg(8'h00, 32'hFF); idle(6);
    idle(2);
    finish_run();
  end
endmodule